// File: doc/BRIEF.md
# Delayed-Scaling Amax History Unit

This block tracks the peak magnitude of one tensor across quantization steps, so that the scale for each step can be prepared ahead of time. While a step is running, it watches the values sent to the quantizer on a multi-lane snoop bus. It keeps the largest absolute value seen in that step. When the step-done strobe arrives, that peak goes into a circular history of the most recent `DEPTH` steps.

A running sum of the history is kept as entries are added and evicted. One cycle after the strobe, a registered average of the history and a power-of-two scale exponent appear at the outputs. The quantizer uses them for the next step. The exponent gives the position of the average's leading one relative to a target bit, `TGT_MSB`, which stands for the largest magnitude the narrow format can hold. A scale of 2^e therefore maps the averaged peak near that target.

The scale that the quantizer applies in step N is built from the peaks of earlier steps. It never waits for the current data. Updating the history therefore never stalls the quantization path.

Top module: `amax_scale_tracker`

## Requirements
- R1: After reset, `scale_exp_o` is 0 (scale 1.0), `amax_avg_o` is 0 and `scale_valid_o` is 0.
- R2: The step peak is the largest magnitude over all lanes of every cycle with `snoop_valid_i` high, up to and including the strobe cycle. Lane data in cycles with `snoop_valid_i` low has no effect.
- R3: Lane samples are two's complement. The most negative code counts as magnitude 2^(DATA_W-1).
- R4: The history holds the last `DEPTH` peaks, and a new peak overwrites the oldest one. Once the history has been filled, `amax_avg_o` equals floor(sum of the stored peaks / DEPTH).
- R5: Before the history has been filled once, `amax_avg_o` equals floor(sum / k), where k is the number of peaks pushed so far.
- R6: `scale_exp_o` (signed) equals msb(`amax_avg_o`) - `TGT_MSB`, clamped to the signed `EXP_W` range. It is 0 when the average is 0. Here msb is the bit index of the leading one.
- R7: The outputs change only on the clock edge one cycle after the edge that samples `step_done_i`. At all other times they hold.
- R8: `scale_valid_o` rises together with the first output update after reset and then stays high.
- R9: The step peak restarts from zero after every strobe. A step with no valid snoop data records a peak of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| snoop_valid_i | input | 1 | Lane data valid this cycle |
| snoop_data_i | input | LANES*DATA_W | Signed samples; lane i at bits [i*DATA_W +: DATA_W] |
| step_done_i | input | 1 | End-of-step strobe, one cycle |
| scale_exp_o | output | EXP_W | Signed scale exponent for the next step |
| scale_valid_o | output | 1 | High once a scale has been produced |
| amax_avg_o | output | DATA_W | Averaged peak that the exponent comes from |

## Verification
On every cycle, the assertions check the following:
- the outputs hold unless a strobe was sampled on the previous edge;
- the valid flag is sticky and rises only after a strobe;
- the exponent's sign and zero case agree with the average against the target bit.

Only the bench scenarios can show the exact arithmetic. This covers the per-step peak across lanes, the ignored invalid data, the most negative code, division by the partial count before fill, and eviction of the oldest entry. The bench checks each of these against an independent history model.

// File: rtl/amx_pkg.sv
package amx_pkg;

  // Bit index of the leading one; -1 for zero.
  function automatic int lead_one(input logic [63:0] v);
    int pos;
    pos = -1;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) pos = i;
    end
    return pos;
  endfunction

  function automatic int clamp_signed(input int v, input int width);
    int hi;
    int lo;
    hi = (1 << (width - 1)) - 1;
    lo = -(1 << (width - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/amx_lane_max.sv
module amx_lane_max #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic [LANES*DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]       max_o
);

  logic [DATA_W-1:0] mag [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] s;
    assign s = data_i[g*DATA_W +: DATA_W];
    // most negative code wraps to 2^(DATA_W-1), read unsigned
    assign mag[g] = s[DATA_W-1] ? (~s + 1'b1) : s;
  end

  always_comb begin
    max_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (mag[i] > max_o) max_o = mag[i];
    end
  end

endmodule

// File: rtl/amx_step_acc.sv
module amx_step_acc #(
  parameter int MAG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [MAG_W-1:0] cyc_max_i,
  input  logic             done_i,
  output logic [MAG_W-1:0] step_max_o
);

  logic [MAG_W-1:0] run_q;

  always_comb begin
    step_max_o = run_q;
    if (valid_i && (cyc_max_i > run_q)) step_max_o = cyc_max_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= '0;
    else if (done_i)  run_q <= '0;
    else if (valid_i) run_q <= step_max_o;
  end

endmodule

// File: rtl/amx_hist_ring.sv
module amx_hist_ring #(
  parameter int MAG_W = 16,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SUM_W = MAG_W + PTR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [MAG_W-1:0] value_i,
  output logic [SUM_W-1:0] sum_o,
  output logic [CNT_W-1:0] count_o
);

  logic [MAG_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full;
  logic [MAG_W-1:0] evict;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign evict = full ? mem_q[wr_ptr_q] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_ptr_q <= '0;
      sum_q    <= '0;
      cnt_q    <= '0;
    end else if (push_i) begin
      mem_q[wr_ptr_q] <= value_i;
      wr_ptr_q        <= wr_ptr_q + 1'b1;  // DEPTH is a power of two
      sum_q           <= sum_q + SUM_W'(value_i) - SUM_W'(evict);
      if (!full) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sum_o   = sum_q;
  assign count_o = cnt_q;

endmodule

// File: rtl/amx_scale_calc.sv
module amx_scale_calc
  import amx_pkg::*;
#(
  parameter int MAG_W   = 16,
  parameter int DEPTH   = 8,
  parameter int TGT_MSB = 8,
  parameter int EXP_W   = 6,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SUM_W  = MAG_W + PTR_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    update_i,
  input  logic [SUM_W-1:0]        sum_i,
  input  logic [CNT_W-1:0]        count_i,
  output logic [MAG_W-1:0]        avg_o,
  output logic signed [EXP_W-1:0] exp_o,
  output logic                    valid_o
);

  logic [MAG_W-1:0]        div_q;
  logic [MAG_W-1:0]        avg_c;
  logic signed [EXP_W-1:0] exp_c;

  // Partial fill: restoring division by a small count.
  // sum < count * 2^MAG_W, so the top PTR_W bits never yield a quotient bit.
  always_comb begin
    logic [CNT_W:0] rem;
    rem   = (CNT_W + 1)'(sum_i[SUM_W-1:MAG_W]);
    div_q = '0;
    for (int i = MAG_W - 1; i >= 0; i--) begin
      rem = {rem[CNT_W-1:0], sum_i[i]};
      if (rem >= {1'b0, count_i}) begin
        rem      = rem - {1'b0, count_i};
        div_q[i] = 1'b1;
      end
    end
  end

  always_comb begin
    if (count_i == CNT_W'(DEPTH)) avg_c = sum_i[SUM_W-1:PTR_W];  // full: shift
    else if (count_i == '0)       avg_c = '0;
    else                          avg_c = div_q;
  end

  always_comb begin
    int e;
    e = 0;
    if (avg_c != '0) e = lead_one(64'(avg_c)) - TGT_MSB;
    exp_c = EXP_W'(clamp_signed(e, EXP_W));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      avg_o   <= '0;
      exp_o   <= '0;
      valid_o <= 1'b0;
    end else if (update_i) begin
      avg_o   <= avg_c;
      exp_o   <= exp_c;
      valid_o <= 1'b1;
    end
  end

endmodule

// File: rtl/amax_scale_tracker.sv
module amax_scale_tracker #(
  parameter int DATA_W  = 16,
  parameter int LANES   = 2,
  parameter int DEPTH   = 8,
  parameter int TGT_MSB = 8,
  parameter int EXP_W   = 6,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int SUM_W  = DATA_W + PTR_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    snoop_valid_i,
  input  logic [LANES*DATA_W-1:0] snoop_data_i,
  input  logic                    step_done_i,
  output logic signed [EXP_W-1:0] scale_exp_o,
  output logic                    scale_valid_o,
  output logic [DATA_W-1:0]       amax_avg_o
);

  logic [DATA_W-1:0] cyc_max;
  logic [DATA_W-1:0] step_max;
  logic [SUM_W-1:0]  hist_sum;
  logic [CNT_W-1:0]  hist_cnt;
  logic              upd_q;

  amx_lane_max #(.DATA_W(DATA_W), .LANES(LANES)) i_lane_max (
    .data_i (snoop_data_i),
    .max_o  (cyc_max)
  );

  amx_step_acc #(.MAG_W(DATA_W)) i_step_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (snoop_valid_i),
    .cyc_max_i  (cyc_max),
    .done_i     (step_done_i),
    .step_max_o (step_max)
  );

  amx_hist_ring #(.MAG_W(DATA_W), .DEPTH(DEPTH)) i_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (step_done_i),
    .value_i (step_max),
    .sum_o   (hist_sum),
    .count_o (hist_cnt)
  );

  // scale is derived from the updated history one edge later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= step_done_i;
  end

  amx_scale_calc #(
    .MAG_W(DATA_W), .DEPTH(DEPTH), .TGT_MSB(TGT_MSB), .EXP_W(EXP_W)
  ) i_scale (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .update_i (upd_q),
    .sum_i    (hist_sum),
    .count_i  (hist_cnt),
    .avg_o    (amax_avg_o),
    .exp_o    (scale_exp_o),
    .valid_o  (scale_valid_o)
  );

endmodule

// File: rtl/amax_scale_tracker_chk.sv
module amax_scale_tracker_chk #(
  parameter int DATA_W  = 16,
  parameter int TGT_MSB = 8,
  parameter int EXP_W   = 6
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    step_done_i,
  input logic signed [EXP_W-1:0] scale_exp_o,
  input logic                    scale_valid_o,
  input logic [DATA_W-1:0]       amax_avg_o
);

  localparam logic [DATA_W-1:0] TGT = DATA_W'(1) << TGT_MSB;

  a_r1_idle_scale_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scale_valid_o |-> (scale_exp_o == '0 && amax_avg_o == '0));

  a_r7_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(step_done_i) |=> ($stable(scale_exp_o) && $stable(amax_avg_o)));

  a_r8_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scale_valid_o |=> scale_valid_o);

  a_r8_valid_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scale_valid_o) |-> $past(step_done_i, 2));

  a_r6_zero_avg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amax_avg_o == '0) |-> (scale_exp_o == '0));

  a_r6_sign_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amax_avg_o >= TGT) |-> (scale_exp_o >= 0));

  a_r6_sign_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (amax_avg_o != '0 && amax_avg_o < TGT) |-> (scale_exp_o < 0));

endmodule

bind amax_scale_tracker amax_scale_tracker_chk #(
  .DATA_W(DATA_W), .TGT_MSB(TGT_MSB), .EXP_W(EXP_W)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .step_done_i   (step_done_i),
  .scale_exp_o   (scale_exp_o),
  .scale_valid_o (scale_valid_o),
  .amax_avg_o    (amax_avg_o)
);

// File: tb/test_amax_scale_tracker.sv
module test_amax_scale_tracker;

  localparam int DATA_W  = 16;
  localparam int LANES   = 2;
  localparam int DEPTH   = 8;
  localparam int TGT_MSB = 8;
  localparam int EXP_W   = 6;

  typedef struct {
    int    avg;
    int    ex;
    string tag;
  } exp_t;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    snoop_valid_i = 1'b0;
  logic [LANES*DATA_W-1:0] snoop_data_i = '0;
  logic                    step_done_i = 1'b0;
  logic signed [EXP_W-1:0] scale_exp_o;
  logic                    scale_valid_o;
  logic [DATA_W-1:0]       amax_avg_o;

  int   total = 0;
  int   bad = 0;
  bit   fin = 1'b0;
  exp_t sb_q[$];
  int   hist[$];
  int   step_peak = 0;

  always #2ns clk_i = ~clk_i;  // 250 MHz

  amax_scale_tracker #(
    .DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH), .TGT_MSB(TGT_MSB), .EXP_W(EXP_W)
  ) i_amax_scale_tracker (
    .clk_i, .rst_ni, .snoop_valid_i, .snoop_data_i, .step_done_i,
    .scale_exp_o, .scale_valid_o, .amax_avg_o
  );

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  function automatic int mag(input int v);
    return v < 0 ? -v : v;
  endfunction

  function automatic int model_exp(input int avg);
    int m;
    int e;
    if (avg == 0) return 0;
    m = 0;
    for (int i = 0; i < 31; i++) if ((avg >> i) & 1) m = i;
    e = m - TGT_MSB;
    if (e > (1 << (EXP_W - 1)) - 1) e = (1 << (EXP_W - 1)) - 1;
    if (e < -(1 << (EXP_W - 1))) e = -(1 << (EXP_W - 1));
    return e;
  endfunction

  // driver: one snoop cycle
  task automatic drive(input bit v, input int a, input int b, input bit done);
    @(negedge clk_i);
    snoop_valid_i = v;
    snoop_data_i  = {DATA_W'(b), DATA_W'(a)};
    step_done_i   = done;
    if (v) begin
      if (mag(a) > step_peak) step_peak = mag(a);
      if (mag(b) > step_peak) step_peak = mag(b);
    end
  endtask

  // driver: closing cycle of a step, model update, push expectation
  task automatic finish_step(input string tag, input bit v, input int a, input int b);
    int   s;
    exp_t e;
    drive(v, a, b, 1'b1);
    hist.push_back(step_peak);
    if (hist.size() > DEPTH) void'(hist.pop_front());
    s = 0;
    foreach (hist[i]) s += hist[i];
    e.avg = s / hist.size();
    e.ex  = model_exp(e.avg);
    e.tag = tag;
    sb_q.push_back(e);
    step_peak = 0;
    drive(1'b0, 0, 0, 1'b0);
  endtask

  // monitor: strobe sampled at edge k, results appear at edge k+1
  initial begin
    int last_avg = 0;
    int last_exp = 0;
    forever begin
      @(posedge clk_i);
      if (rst_ni && step_done_i) begin
        exp_t e;
        @(negedge clk_i);
        chk("R7 hold avg before update", int'(amax_avg_o), last_avg);
        chk("R7 hold exp before update", int'(scale_exp_o), last_exp);
        @(negedge clk_i);
        if (sb_q.size() == 0) begin
          chk("R7 unexpected update", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk({e.tag, " avg"}, int'(amax_avg_o), e.avg);
          chk("R6 exponent", int'(scale_exp_o), e.ex);
          chk("R8 valid", int'(scale_valid_o), 1);
          last_avg = e.avg;
          last_exp = e.ex;
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset exp", int'(scale_exp_o), 0);
    chk("R1 reset avg", int'(amax_avg_o), 0);
    chk("R1 reset valid", int'(scale_valid_o), 0);
    rst_ni = 1'b1;
    drive(1'b0, 0, 0, 1'b0);
    chk("R8 valid low before first strobe", int'(scale_valid_o), 0);

    // R2: peak across lanes and cycles; invalid strobe-cycle data ignored
    drive(1'b1, 100, -50, 1'b0);
    drive(1'b1, 20, 300, 1'b0);
    finish_step("R2 lane max", 1'b0, 9000, 9000);

    // R2/R5: invalid cycle ignored, strobe-cycle data counted, partial average
    drive(1'b0, 30000, 30000, 1'b0);
    drive(1'b1, -700, 5, 1'b0);
    finish_step("R5 partial average", 1'b1, 10, -1000);

    // R3: most negative code
    finish_step("R3 most negative", 1'b1, -32768, 0);

    // R9: peak restarts from zero
    drive(1'b1, 1, 0, 1'b0);
    finish_step("R9 peak cleared", 1'b1, 2, -1);

    // R9: empty step
    finish_step("R9 empty step", 1'b0, 0, 0);

    // R4: fill and wrap the history
    for (int k = 0; k < 10; k++) begin
      drive(1'b1, k * 37 + 5, -(k * 411), 1'b0);
      drive(1'b0, 32000, 0, 1'b0);
      finish_step("R4 eviction", 1'b1, k, 3);
    end

    // R6: small averages give negative exponents, zero gives zero
    for (int k = 0; k < DEPTH; k++) finish_step("R6 small avg", 1'b1, 40, -17);
    for (int k = 0; k < DEPTH; k++) finish_step("R6 zero avg", 1'b0, 0, 0);

    // R7: long idle with snoop traffic, outputs must hold
    for (int k = 0; k < 6; k++) begin
      drive(1'b1, 20000, -20000, 1'b0);
      chk("R7 hold during step exp", int'(scale_exp_o), 0);
      chk("R7 hold during step avg", int'(amax_avg_o), 0);
    end
    finish_step("R4 after hold", 1'b0, 0, 0);

    repeat (4) @(negedge clk_i);
    chk("R7 scoreboard drained", sb_q.size(), 0);
    fin = 1'b1;
    summary();
    $finish;
  end

endmodule